// File: doc/BRIEF.md
# Memory Power-Up Initialization Sequencer

This block brings a DDR2-class memory device from power-on to a usable state. Once reset is released, it raises clock enable and holds the command bus at NOP for a minimum settling time, expressed as a number of clock cycles. It then issues a fixed series of nine commands: precharges, mode-register writes and refreshes. A programmable number of NOP cycles separates each command from the next. When the series is finished, it raises a done flag.

The main mode word is built from configuration inputs. These are burst length, burst ordering, CAS latency and a write-recovery time given in nanoseconds, which the block rounds up to whole clock cycles. Every mode-register write carries a complete word. Once the series is finished, the block produces a one-cycle refresh request at a fixed interval. A high-temperature input halves that interval, starting from the next timer reload. Sharing the command bus with user traffic is handled elsewhere.

Top module: `dram_init_seq`

## Requirements
- R1: `cke_o` is low while reset is asserted, is high after the first rising clock edge following reset release, and does not fall again until the next reset.
- R2: For the first INIT_CYC cycles with `cke_o` high (INIT_CYC = ceil(INIT_NS·1000/TCK_PS), 100 by default), the bus holds NOP. No command appears before the cycle that follows edge INIT_CYC+1 after reset release. NOP is `cmd_o`=3'b111 with `bank_o`=0 and `addr_o`=0.
- R3: The nine commands follow a fixed order, with `cmd_o` = {ras_n, cas_n, we_n}. The order is:
  - precharge-all: `cmd_o`=3'b010, `addr_o[10]`=1;
  - mode write to bank 2;
  - mode write to bank 3;
  - mode write to bank 1;
  - mode write to bank 0 with DLL reset;
  - precharge-all;
  - refresh (`cmd_o`=3'b001);
  - refresh;
  - mode write to bank 0 without DLL reset.
  A mode write is `cmd_o`=3'b000.
- R4: Each command is one cycle long. Exactly `cfg_gap` NOP cycles follow each command, including the last one.
- R5: A bank-0 mode word carries these fields: burst length in `addr_o[2:0]` (3'b010 for 4, 3'b011 for 8 when `cfg_bl8`=1); burst ordering in bit 3 (`cfg_ilv`); CAS latency in bits 6:4 (`cfg_cl`); test mode in bit 7, always 0; DLL reset in bit 8, set only in the first bank-0 write. All other bits are 0.
- R6: The write-recovery field `addr_o[11:9]` holds n−1, where n = ceil(`cfg_twr_ns`·1000/TCK_PS), with n clamped to the range 2 to 8.
- R7: The bank-2 and bank-3 mode words are all zero. The bank-1 word is all zero as well, which leaves the DLL enabled because bit 0 is 0.
- R8: `init_done_o` rises in the cycle that follows the gap after the last command, then stays high until reset.
- R9: After done, `ref_req_o` pulses for one cycle. The first pulse comes in the P-th cycle with done high, and later pulses follow every P cycles. P is REF_CYC = REF_NS·1000/TCK_PS (1950 by default).
- R10: `hot_i` is sampled at the edge that enters done and at the edge that ends each request cycle. When it is high there, the next interval is REF_CYC/2 (975) instead of REF_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bl8 | input | 1 | Burst of 8 when 1, burst of 4 when 0 |
| cfg_ilv | input | 1 | Interleaved burst ordering |
| cfg_cl | input | 3 | CAS latency code |
| cfg_twr_ns | input | 5 | Write-recovery time in ns |
| cfg_gap | input | GAP_W | NOP cycles after each command |
| hot_i | input | 1 | High case temperature |
| cke_o | output | 1 | Clock enable to memory |
| cmd_o | output | 3 | {ras_n, cas_n, we_n} |
| bank_o | output | 2 | Bank / mode-register select |
| addr_o | output | ADDR_W | Address / mode word |
| init_done_o | output | 1 | Initialization complete |
| ref_req_o | output | 1 | One-cycle refresh request |

## Verification
The assertions check several properties on every cycle:
- clock enable never drops;
- no command appears while clock enable is low;
- a NOP follows every command when the gap is non-zero;
- the bank-3 word is zero;
- done never falls;
- a refresh request occurs only when done is high and never lasts two cycles in a row.

Some properties can only be shown by the bench's scenarios, which compare every cycle against a behavioural model over several configurations:
- the exact length of the initial wait;
- the order of the commands;
- the mode-word contents for each burst length and ordering, CAS latency and write-recovery rounding and clamping case;
- the exact cycle at which done rises;
- the refresh interval and its switch when temperature changes.

// File: rtl/dram_init_seq.sv
module dram_init_seq #(
  parameter int TCK_PS  = 4000,
  parameter int INIT_NS = 400,
  parameter int REF_NS  = 7800,
  parameter int GAP_W   = 4,
  parameter int ADDR_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bl8,
  input  logic              cfg_ilv,
  input  logic [2:0]        cfg_cl,
  input  logic [4:0]        cfg_twr_ns,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              hot_i,
  output logic              cke_o,
  output logic [2:0]        cmd_o,
  output logic [1:0]        bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o,
  output logic              ref_req_o
);
  localparam int INIT_CYC    = (INIT_NS * 1000 + TCK_PS - 1) / TCK_PS;
  localparam int REF_CYC     = REF_NS * 1000 / TCK_PS;
  localparam int REF_HOT_CYC = REF_CYC / 2;
  localparam int CNT_MAX     = (INIT_CYC > (1 << GAP_W)) ? INIT_CYC : (1 << GAP_W);
  localparam int CW          = $clog2(CNT_MAX + 1);
  localparam int RW          = $clog2(REF_CYC + 1);
  localparam logic [3:0] LAST_STEP = 4'd8;
  localparam logic [2:0] C_NOP = 3'b111, C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;

  typedef enum logic [1:0] {S_WAIT, S_CMD, S_GAP, S_DONE} st_t;

  st_t            st;
  logic [3:0]     step;
  logic [CW-1:0]  cnt;
  logic [RW-1:0]  rcnt;
  logic           cke_q;
  logic [31:0]    wr_raw;
  logic [2:0]     wr_code;
  logic [ADDR_W-1:0] mr_word;
  logic           adv;
  logic [RW-1:0]  reload;

  assign wr_raw  = (32'(cfg_twr_ns) * 32'd1000 + 32'(TCK_PS - 1)) / 32'(TCK_PS);
  assign wr_code = (wr_raw < 32'd2) ? 3'd1 : (wr_raw > 32'd8) ? 3'd7 : 3'(wr_raw - 32'd1);
  assign reload  = hot_i ? RW'(REF_HOT_CYC - 1) : RW'(REF_CYC - 1);
  assign adv     = (st == S_CMD && cfg_gap == '0) || (st == S_GAP && cnt == CW'(cfg_gap));

  always_comb begin
    mr_word       = '0;
    mr_word[2:0]  = cfg_bl8 ? 3'b011 : 3'b010;
    mr_word[3]    = cfg_ilv;
    mr_word[6:4]  = cfg_cl;
    mr_word[8]    = (step == 4'd4);
    mr_word[11:9] = wr_code;
  end

  always_comb begin
    cmd_o  = C_NOP;
    bank_o = 2'd0;
    addr_o = '0;
    if (st == S_CMD) begin
      case (step)
        4'd0, 4'd5: begin cmd_o = C_PRE; addr_o[10] = 1'b1; end
        4'd1:       begin cmd_o = C_MRS; bank_o = 2'd2; end
        4'd2:       begin cmd_o = C_MRS; bank_o = 2'd3; end
        4'd3:       begin cmd_o = C_MRS; bank_o = 2'd1; end
        4'd4, 4'd8: begin cmd_o = C_MRS; addr_o = mr_word; end
        4'd6, 4'd7: cmd_o = C_REF;
        default:    cmd_o = C_NOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_WAIT;
      step  <= '0;
      cnt   <= '0;
      rcnt  <= '0;
      cke_q <= 1'b0;
    end else begin
      cke_q <= 1'b1;
      if (adv) begin
        if (step == LAST_STEP) begin
          st   <= S_DONE;
          rcnt <= reload;
        end else begin
          st   <= S_CMD;
          step <= step + 4'd1;
        end
      end else begin
        case (st)
          S_WAIT: if (cnt == CW'(INIT_CYC)) st <= S_CMD; else cnt <= cnt + 1'b1;
          S_CMD:  begin st <= S_GAP; cnt <= CW'(1); end
          S_GAP:  cnt <= cnt + 1'b1;
          S_DONE: rcnt <= (rcnt == '0) ? reload : rcnt - 1'b1;
          default: st <= S_WAIT;
        endcase
      end
    end
  end

  assign cke_o       = cke_q;
  assign init_done_o = (st == S_DONE);
  assign ref_req_o   = (st == S_DONE) && (rcnt == '0);

  // R1
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) cke_o |=> cke_o);
  // R2
  cold_nop_chk: assert property (@(posedge clk) disable iff (!rst_n) !cke_o |-> cmd_o == C_NOP);
  // R4
  gap_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != C_NOP && cfg_gap != '0) |=> cmd_o == C_NOP);
  // R7
  emr3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == C_MRS && bank_o == 2'd3) |-> addr_o == '0);
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) init_done_o |=> init_done_o);
  // R9
  req_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n) ref_req_o |-> init_done_o);
  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ref_req_o |=> !ref_req_o);
endmodule

// File: tb/dram_init_seq_tb.sv
module dram_init_seq_tb_top;
  localparam int TCK_PS = 4000, INIT_NS = 400, REF_NS = 7800, GAP_W = 4, ADDR_W = 14;
  localparam int W   = (INIT_NS * 1000 + TCK_PS - 1) / TCK_PS;
  localparam int REF = REF_NS * 1000 / TCK_PS;
  localparam int HOT = REF / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_bl8 = 1'b0, cfg_ilv = 1'b0, hot_i = 1'b0;
  logic [2:0] cfg_cl = 3'd3;
  logic [4:0] cfg_twr_ns = 5'd15;
  logic [GAP_W-1:0] cfg_gap = '0;
  logic cke_o, init_done_o, ref_req_o;
  logic [2:0] cmd_o;
  logic [1:0] bank_o;
  logic [ADDR_W-1:0] addr_o;

  int total = 0, bad = 0, k = 0, nreq = -1, cyc = 0;

  always #2 clk = ~clk;

  dram_init_seq #(.TCK_PS(TCK_PS), .INIT_NS(INIT_NS), .REF_NS(REF_NS), .GAP_W(GAP_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bl8(cfg_bl8), .cfg_ilv(cfg_ilv), .cfg_cl(cfg_cl),
    .cfg_twr_ns(cfg_twr_ns), .cfg_gap(cfg_gap), .hot_i(hot_i), .cke_o(cke_o), .cmd_o(cmd_o),
    .bank_o(bank_o), .addr_o(addr_o), .init_done_o(init_done_o), .ref_req_o(ref_req_o));

  function automatic int g1();
    return int'(cfg_gap) + 1;
  endfunction

  function automatic int done_at();
    return W + 1 + 9 * g1();
  endfunction

  // R6: rounded-up write recovery, clamped 2..8, coded as n-1
  function automatic int wr_field();
    int n;
    n = (int'(cfg_twr_ns) * 1000 + TCK_PS - 1) / TCK_PS;
    if (n < 2) n = 2;
    if (n > 8) n = 8;
    return n - 1;
  endfunction

  // R5: bank-0 mode word
  function automatic int mr_exp(int dll);
    return (cfg_bl8 ? 3 : 2) + 8 * int'(cfg_ilv) + 16 * int'(cfg_cl) + 256 * dll + 512 * wr_field();
  endfunction

  // reference model state
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      k = 0; nreq = -1;
    end else begin
      k++;
      if (k == done_at() || k == nreq + 1) nreq = k + (hot_i ? HOT : REF) - 1;
    end
  end

  task automatic fail(string tag, string what, int act, int exp);
    bad++;
    $display("FAIL %s %s k=%0d actual=%0h expected=%0h", tag, what, k, act, exp);
  endtask

  always @(negedge clk) begin
    int ecmd, ebank, eaddr, step, t;
    string tag;
    bit ecke, edone, ereq;
    ecke = (k >= 1);
    ecmd = 7; ebank = 0; eaddr = 0; step = -1;
    t = k - (W + 1);
    tag = (k <= W) ? "R2" : "R4";
    if (k >= 1 && t >= 0 && t < 9 * g1() && (t % g1()) == 0) begin
      step = t / g1();
      tag = "R3";
      case (step)
        0, 5: begin ecmd = 2; eaddr = 1024; end
        1: begin ecmd = 0; ebank = 2; tag = "R7"; end
        2: begin ecmd = 0; ebank = 3; tag = "R7"; end
        3: begin ecmd = 0; ebank = 1; tag = "R7"; end
        4: begin ecmd = 0; eaddr = mr_exp(1); tag = "R5"; end
        8: begin ecmd = 0; eaddr = mr_exp(0); tag = "R5"; end
        default: ecmd = 1;
      endcase
    end
    edone = (k >= done_at());
    ereq  = edone && (k == nreq);
    total++;
    if (cke_o !== ecke) fail("R1", "cke", int'(cke_o), int'(ecke));
    else if (int'(cmd_o) != ecmd) fail(tag == "R5" || tag == "R7" ? "R3" : tag, "cmd", int'(cmd_o), ecmd);
    else if (int'(bank_o) != ebank) fail(tag, "bank", int'(bank_o), ebank);
    else if (int'(addr_o) != eaddr)
      fail((tag == "R5" && int'(addr_o[11:9]) != wr_field()) ? "R6" : tag, "addr", int'(addr_o), eaddr);
    else if (init_done_o !== edone) fail("R8", "done", int'(init_done_o), int'(edone));
    else if (ref_req_o !== ereq) fail(hot_i ? "R10" : "R9", "ref_req", int'(ref_req_o), int'(ereq));
  end

  always @(posedge clk) if (cyc > 200000) begin
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic run(bit bl8, bit ilv, int cl, int twr, int gap, bit hot0, bit hot1);
    @(negedge clk); #1;
    rst_n = 1'b0;
    cfg_bl8 = bl8; cfg_ilv = ilv; cfg_cl = 3'(cl); cfg_twr_ns = 5'(twr);
    cfg_gap = GAP_W'(gap); hot_i = hot0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
    repeat (W + 9 * (gap + 1) + 2 * HOT) @(posedge clk);
    @(negedge clk); #1;
    hot_i = hot1;
    repeat (2 * REF + 50) @(posedge clk);
  endtask

  initial begin
    // R1 R2 R3 R4 R5 R6 R7 R8 R9: gap 0, burst 4, 15 ns -> 4 cycles
    run(1'b0, 1'b0, 3, 15, 0, 1'b0, 1'b1);
    // R10: starts hot, then normal; burst 8 interleaved, 5 ns -> 2 cycles
    run(1'b1, 1'b1, 5, 5, 3, 1'b1, 1'b0);
    // R6 clamp low: 1 ns -> 1 cycle -> 2
    run(1'b0, 1'b1, 6, 1, 15, 1'b0, 1'b0);
    // R6 top: 31 ns -> 8 cycles
    run(1'b1, 1'b0, 4, 31, 1, 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule